// File: doc/BRIEF.md
# Multi-Address I2C Register Target

This block is a slave-only I2C target that gives a host access to a byte-wide control register file. Both bus lines are oversampled by the fast system clock. SDA is only ever pulled low, through an output-enable, and the block never drives SCL. The target detects START, repeated START and STOP. It takes in the address byte and acknowledges it when it matches. It then either writes bytes through a register pointer or streams bytes out from that pointer.

In its default build the target answers a group of four adjacent 7-bit addresses starting at 0x48. It reports which of the four was matched, so that the register back end can select one of four banks. A parameter turns the same code into a single-address target.

The target also recognises the high-speed master code. It does not acknowledge that code, and it flags high-speed operation until the next STOP. The register store sits outside the block, behind a write strobe and a read strobe. Both strobes share one pointer address. Read data must be valid in the same cycle as the read strobe.

Top module: `i2c_multi_target`

## Requirements
- R1: With ID_COUNT=4 and BASE_ID=0x48, the target acknowledges each of the addresses 0x48, 0x49, 0x4A and 0x4B. An acknowledge means sda_oe is high during the whole high phase of the ninth SCL pulse.
- R2: Any other address is not acknowledged. The target then keeps sda_oe low and issues no register strobe until the next START or STOP.
- R3: On an address acknowledge, bank_sel takes the two low bits of the matched address (0x48 gives 0, 0x4B gives 3). An address that is not acknowledged leaves bank_sel unchanged.
- R4: In a write, the first data byte loads the 8-bit pointer. Each later byte gives one reg_wr_en pulse with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then increments and wraps from 0xFF to 0x00. Every data byte is acknowledged.
- R5: In a read, the target sends the byte at the pointer MSB first (a 0 bit is sda_oe high). The pointer increments after each byte. The pointer is kept from one transfer to the next, including across a repeated START.
- R6: A master NACK (SDA high in the ninth clock of a read byte) ends the read. The target leaves SDA released until the next START.
- R7: An address byte of the form 00001xxx is not acknowledged and sets hs_mode. hs_mode stays high through any repeated START and clears at STOP.
- R8: sda_oe changes only while the synchronised SCL is low. SDA is sampled on the SCL rising edge.
- R9: A repeated START restarts the address phase at any point in a transfer. A STOP returns the target to idle with SDA released.
- R10: With ID_COUNT=1, the target acknowledges only BASE_ID.
- R11: After reset, sda_oe, hs_mode, bank_sel, reg_wr_en and reg_rd_en are all 0.
- R12: Correct operation needs SCL high and low phases of at least 5 system clocks. This covers every bus rate whose phases meet that bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level at the pad |
| sda_i | input | 1 | SDA level at the pad |
| sda_oe | output | 1 | High pulls SDA low |
| bank_sel | output | BANK_W | Index of the matched address within the group |
| hs_mode | output | 1 | High-speed master code seen since the last STOP |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the cycle of reg_rd_en |

## Verification
Each SCL edge at the pad reaches the state logic through two synchroniser flops and one edge-detect flop. sda_oe therefore moves on the third system-clock edge after an SCL fall. The bench drives its inputs on falling clock edges and holds each SCL phase for at least 5 clocks. Its reference model expects a given sda_oe value only from the clock after SCL rises until SCL falls. In that window it compares both instances on every clock, which checks acknowledges, read bits and release in every bus bit. It also checks each write strobe in the cycle it appears against a queue of expected writes, and it samples bank_sel and hs_mode only while the bus is quiet after an acknowledge, a START or a STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_DEC,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_DEC,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_RD_LOAD
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_rst_sync.sv
module i2c_tgt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int STAGES = 3;

  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
    end
  end

  assign scl_s    = scl_pipe_q[STAGES-2];
  assign sda_s    = sda_pipe_q[STAGES-2];
  assign scl_prev = scl_pipe_q[STAGES-1];
  assign sda_prev = sda_pipe_q[STAGES-1];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match #(
  parameter int              ID_COUNT = 4,
  parameter logic [6:0]      BASE_ID  = 7'h48,
  parameter int              BANK_W   = 2
) (
  input  logic [6:0]        addr,
  output logic              hit,
  output logic [BANK_W-1:0] bank
);
  localparam int IDW = $clog2(ID_COUNT);

  generate
    if (ID_COUNT == 1) begin : g_single
      assign hit  = (addr == BASE_ID);
      assign bank = '0;
    end else begin : g_group
      assign hit  = (addr[6:IDW] == BASE_ID[6:IDW]);
      assign bank = addr[IDW-1:0];
    end
  endgenerate
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit,
  input  logic [BANK_W-1:0] hit_bank,
  output logic [ADDR_W-1:0] rx_addr,
  output logic              sda_oe,
  output logic [BANK_W-1:0] bank_sel,
  output logic              hs_mode,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [4:0] HS_CODE = 5'b00001;

  tgt_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] ptr_q, ptr_n;
  logic              first_q, first_n;
  logic              rw_q, rw_n;
  logic              oe_q, oe_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic              hs_q, hs_n;
  logic              wr_stb, rd_stb;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    first_n = first_q;
    rw_n    = rw_q;
    oe_n    = oe_q;
    bank_n  = bank_q;
    hs_n    = hs_q;
    wr_stb  = 1'b0;
    rd_stb  = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      hs_n    = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
      first_n = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT)
              state_n = (state_q == ST_ADDR) ? ST_ADDR_DEC : ST_WR_DEC;
          end
        end
        ST_ADDR_DEC: begin
          if (scl_fall) begin
            if (hit) begin
              oe_n    = 1'b1;
              bank_n  = hit_bank;
              rw_n    = sh_q[0];
              state_n = ST_ADDR_ACK;
            end else begin
              if (sh_q[7:3] == HS_CODE) hs_n = 1'b1;
              state_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_RD_LOAD: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (state_q == ST_RD_LOAD || rw_q) begin
              rd_stb  = 1'b1;
              sh_n    = reg_rdata;
              oe_n    = ~reg_rdata[BYTE_W-1];
              ptr_n   = ptr_q + 1'b1;
              state_n = ST_RD_BYTE;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_WR_BYTE;
            end
          end
        end
        ST_WR_DEC: begin
          if (scl_fall) begin
            oe_n    = 1'b1;
            state_n = ST_WR_ACK;
            if (first_q) begin
              ptr_n   = sh_q;
              first_n = 1'b0;
            end else begin
              wr_stb = 1'b1;
              ptr_n  = ptr_q + 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            cnt_n   = '0;
            state_n = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_n    = 1'b0;
              state_n = ST_RD_ACK;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n  = ~sh_q[BYTE_W-2];
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) state_n = sda_s ? ST_IDLE : ST_RD_LOAD;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      bank_q  <= '0;
      hs_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      first_q <= first_n;
      rw_q    <= rw_n;
      oe_q    <= oe_n;
      bank_q  <= bank_n;
      hs_q    <= hs_n;
    end
  end

  assign rx_addr   = sh_q[BYTE_W-1:1];
  assign sda_oe    = oe_q;
  assign bank_sel  = bank_q;
  assign hs_mode   = hs_q;
  assign reg_wr_en = wr_stb;
  assign reg_rd_en = rd_stb;
  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s) else $error("sda_oe moved with SCL high"); // R8
  AST_ACK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_DEC && scl_fall && hit) |=> oe_q) else $error("matched address not acknowledged"); // R1
  AST_BANK_ONLY_AT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(state_q) == ST_ADDR_DEC) else $error("bank_sel moved outside address decode"); // R3
  AST_HS_CLEARED_BY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_q) else $error("hs_mode survived STOP"); // R7
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR && !oe_q)) else $error("START did not restart address phase"); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!oe_q && !wr_stb && !rd_stb)) else $error("idle target drives bus or strobes"); // R2
endmodule

// File: rtl/i2c_multi_target.sv
module i2c_multi_target
  import i2c_tgt_pkg::*;
#(
  parameter int         ID_COUNT = 4,
  parameter logic [6:0] BASE_ID  = 7'h48,
  parameter int         BANK_W   = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BANK_W-1:0] bank_sel,
  output logic              hs_mode,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [7:0]        reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  logic rst_sn;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hit;
  logic [BANK_W-1:0] hit_bank;
  logic [ADDR_W-1:0] rx_addr;

  i2c_tgt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  i2c_tgt_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_addr_match #(
    .ID_COUNT (ID_COUNT),
    .BASE_ID  (BASE_ID),
    .BANK_W   (BANK_W)
  ) u_match (
    .addr (rx_addr),
    .hit  (hit),
    .bank (hit_bank)
  );

  i2c_tgt_fsm #(
    .BANK_W (BANK_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .hit       (hit),
    .hit_bank  (hit_bank),
    .rx_addr   (rx_addr),
    .sda_oe    (sda_oe),
    .bank_sel  (bank_sel),
    .hs_mode   (hs_mode),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: tb/test_i2c_multi_target.sv
module test_i2c_multi_target;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  wire  line;

  logic       oe_a, hs_a, wr_a, rd_a;
  logic [1:0] bank_a;
  logic [7:0] addr_a, wdata_a, rdata_a;
  logic       oe_b, hs_b, wr_b, rd_b;
  logic [0:0] bank_b;
  logic [7:0] addr_b, wdata_b;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] exp_wr_q [$];
  logic [7:0]  bptr;
  int          h = 8;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  logic        exp_on = 1'b0;
  logic        exp_a = 1'b0;
  logic        exp_b = 1'b0;
  string       exp_tag = "";

  assign line    = m_sda & ~oe_a & ~oe_b;
  assign rdata_a = mem[addr_a];

  always #(CLK_P/2) clk = ~clk;

  i2c_multi_target i_i2c_multi_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(line),
    .sda_oe(oe_a), .bank_sel(bank_a), .hs_mode(hs_a),
    .reg_wr_en(wr_a), .reg_rd_en(rd_a), .reg_addr(addr_a),
    .reg_wdata(wdata_a), .reg_rdata(rdata_a)
  );

  i2c_multi_target #(.ID_COUNT(1), .BASE_ID(7'h12)) i_i2c_multi_target_single (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(line),
    .sda_oe(oe_b), .bank_sel(bank_b), .hs_mode(hs_b),
    .reg_wr_en(wr_b), .reg_rd_en(rd_b), .reg_addr(addr_b),
    .reg_wdata(wdata_b), .reg_rdata(8'h00)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // back end store written by the design's strobe
  always @(posedge clk) if (wr_a) mem[addr_a] <= wdata_a;

  // per-clock reference comparison
  always @(posedge clk) begin
    #(CLK_P/4);
    cycles++;
    if (exp_on) begin
      chk({exp_tag, " oe main"}, oe_a, exp_a);
      chk({exp_tag, " oe single"}, oe_b, exp_b);
    end
    if (wr_a) begin
      if (exp_wr_q.size() == 0) chk("R2 R4 spurious write", {addr_a, wdata_a}, 0);
      else chk("R4 write strobe", {addr_a, wdata_a}, exp_wr_q.pop_front());
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL pulse; bit b driven by master, expectation on both targets
  task automatic clk_bit(input logic b, input logic ea, input logic eb,
                         input string tag, output logic got);
    m_sda = b;
    wait_n(h);
    exp_a = ea; exp_b = eb; exp_tag = tag;
    m_scl = 1'b1;
    exp_on = 1'b1;
    wait_n(h / 2);
    got = line;
    wait_n(h - h / 2);
    m_scl = 1'b0;
    exp_on = 1'b0;
  endtask

  task automatic do_start();
    m_sda = 1'b1; m_scl = 1'b1;
    wait_n(h);
    m_sda = 1'b0;
    wait_n(h);
    m_scl = 1'b0;
  endtask

  task automatic do_rstart();
    m_sda = 1'b1;
    wait_n(h);
    m_scl = 1'b1;
    wait_n(h);
    m_sda = 1'b0;
    wait_n(h);
    m_scl = 1'b0;
  endtask

  task automatic do_stop();
    m_sda = 1'b0;
    wait_n(h);
    m_scl = 1'b1;
    wait_n(h);
    m_sda = 1'b1;
    wait_n(h);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack_a,
                           input logic ack_b, input string tag);
    logic got;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, 1'b0, {tag, " R8 data"}, got);
    clk_bit(1'b1, ack_a, ack_b, {tag, " ack"}, got);
    chk({tag, " ack line"}, got, !(ack_a || ack_b));
  endtask

  task automatic recv_byte(input logic [7:0] e, input logic mack, input string tag);
    logic got;
    logic [7:0] acc;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~e[i], 1'b0, {tag, " read bit"}, got);
      acc[i] = got;
    end
    clk_bit(~mack, 1'b0, 1'b0, {tag, " master ack"}, got);
    chk({tag, " read byte"}, acc, e);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bptr = p;
    send_byte(p, 1'b1, 1'b0, "R4 pointer");
  endtask

  task automatic wr_data(input logic [7:0] b);
    exp_wr_q.push_back({bptr, b});
    exp_mem[bptr] = b;
    bptr = bptr + 1'b1;
    send_byte(b, 1'b1, 1'b0, "R4 data");
  endtask

  task automatic rd_data(input logic mack);
    recv_byte(exp_mem[bptr], mack, "R5");
    bptr = bptr + 1'b1;
  endtask

  initial begin
    logic got;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    bptr = 8'h00;
    wait_n(4);
    chk("R11 sda_oe", oe_a, 0);
    chk("R11 hs_mode", hs_a, 0);
    chk("R11 bank_sel", bank_a, 0);
    chk("R11 strobes", {wr_a, rd_a}, 0);
    chk("R11 single sda_oe", oe_b, 0);
    rst_n = 1'b1;
    wait_n(6);

    // write burst at 0x48
    do_start();
    send_byte({7'h48, 1'b0}, 1'b1, 1'b0, "R1 0x48");
    chk("R3 bank 0x48", bank_a, 0);
    set_ptr(8'h10);
    wr_data(8'hA1); wr_data(8'hB2); wr_data(8'hC3);
    do_stop();

    // pointer write, repeated START, read back at 0x4B
    do_start();
    send_byte({7'h4B, 1'b0}, 1'b1, 1'b0, "R1 0x4B");
    chk("R3 bank 0x4B", bank_a, 3);
    set_ptr(8'h10);
    do_rstart();
    send_byte({7'h4B, 1'b1}, 1'b1, 1'b0, "R9 rstart read");
    rd_data(1'b1); rd_data(1'b1); rd_data(1'b0);
    do_stop();

    // foreign address: ignored bytes, bank kept
    do_start();
    send_byte({7'h4C, 1'b0}, 1'b0, 1'b0, "R2 0x4C");
    send_byte(8'h20, 1'b0, 1'b0, "R2 ignored");
    send_byte(8'h55, 1'b0, 1'b0, "R2 ignored");
    do_stop();
    chk("R3 bank kept after NACK", bank_a, 3);

    // shortest phases, pointer wrap at 0x4A
    h = 5;
    do_start();
    send_byte({7'h4A, 1'b0}, 1'b1, 1'b0, "R12 R1 0x4A");
    chk("R3 bank 0x4A", bank_a, 2);
    set_ptr(8'hFE);
    wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
    do_stop();
    do_start();
    send_byte({7'h4A, 1'b0}, 1'b1, 1'b0, "R12 0x4A");
    set_ptr(8'hFE);
    do_rstart();
    send_byte({7'h4A, 1'b1}, 1'b1, 1'b0, "R12 read");
    rd_data(1'b1); rd_data(1'b1); rd_data(1'b0);
    do_stop();

    // high-speed entry
    do_start();
    send_byte(8'h0B, 1'b0, 1'b0, "R7 master code");
    chk("R7 hs set", hs_a, 1);
    do_rstart();
    chk("R7 hs kept over rstart", hs_a, 1);
    send_byte({7'h49, 1'b0}, 1'b1, 1'b0, "R7 R1 0x49");
    chk("R3 bank 0x49", bank_a, 1);
    set_ptr(8'h05);
    wr_data(8'h66);
    chk("R7 hs in transfer", hs_a, 1);
    do_stop();
    chk("R7 hs cleared", hs_a, 0);
    h = 8;

    // single-address build
    do_start();
    send_byte({7'h12, 1'b0}, 1'b0, 1'b1, "R10 0x12");
    send_byte(8'h03, 1'b0, 1'b1, "R10 ptr");
    do_stop();

    // read from kept pointer, master NACK ends it
    do_start();
    send_byte({7'h48, 1'b1}, 1'b1, 1'b0, "R5 read 0x48");
    rd_data(1'b0);
    clk_bit(1'b1, 1'b0, 1'b0, "R6 released after NACK", got);
    clk_bit(1'b1, 1'b0, 1'b0, "R6 released after NACK", got);
    do_stop();
    chk("R3 bank 0x48 again", bank_a, 0);
    chk("R4 pending writes", exp_wr_q.size(), 0);
    chk("R6 sda idle", oe_a, 0);
    wait_n(4);
    finish_run();
  end
endmodule